// File: doc/BRIEF.md
# GF(2^233) Trinomial Reduction Unit

This block takes a 465-bit polynomial over GF(2), the full width of a carry-less product of two 233-bit field elements or of a squared element, and returns its remainder modulo x^233 + x^74 + 1 as a 233-bit field element. Folding uses only XOR gates. Each input bit at position i of 233 or above is replaced by bits at i-233 and i-159, because x^233 ≡ x^74 + 1. The middle exponent lies below half the field degree, so a small fixed number of folds brings every input into range. With the default widths that number is two. There is no iteration and no lookup.

A multiplier or squarer drives `prod_i`. The caller raises `en_i` for one cycle, and the reduced value appears on `rem_o` after that clock edge. The value stays on `rem_o` until the next enabled edge. The output register has an asynchronous clear, and its release is synchronized inside the block. A parameter can remove the register, which leaves a purely combinational path.

Top module: `gf233_reduce`

## Requirements
- R1: After a rising edge with `en_i` high, `rem_o` holds the unique polynomial of degree below 233 that is congruent to the sampled `prod_i` modulo x^233 + x^74 + 1 (bit k carries the coefficient of x^k). An all-zero input gives zero, and x^233 + 1 gives x^74 alone.
- R2: An input whose bits 464 to 233 are all zero appears unchanged on `rem_o`.
- R3: A single set bit at position 233 gives bits 0 and 74. A single bit at 306 gives bits 73 and 147, and a single bit at 307 gives bits 74 and 148.
- R4: A single set bit at position 464, which needs a second fold, gives exactly bits 72, 146 and 231.
- R5: While `en_i` is low, `rem_o` keeps its value whatever `prod_i` does.
- R6: Driving `rst_n` low forces `rem_o` to zero without waiting for a clock edge.
- R7: After `rst_n` rises, the first two rising edges ignore `en_i`, and the third rising edge loads as usual.
- R8: The mapping is linear: the result for a XOR b equals the XOR of the results for a and for b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Load enable for the output register |
| prod_i | input | 465 | Unreduced polynomial, bit k is the coefficient of x^k |
| rem_o | output | 233 | Reduced field element |

## Verification
The assertions assume the caller changes `en_i` and `prod_i` only between edges. They also assume `en_i` stays low until the internal reset release has completed; otherwise a load could be swallowed and the one-cycle relations would not hold. The stimulus follows both rules. It drives every input on the falling edge and keeps `en_i` low during reset, except in one deliberate probe of the release window, and the checker is disabled during that probe. The single-bit and passthrough properties fire only on the exact input patterns they name.

// File: rtl/gf233_pkg.sv
package gf233_pkg;

  localparam int DEF_FIELD_M = 233;
  localparam int DEF_MID_N   = 74;

  // Width of a polynomial of width w after one fold of all bits >= m.
  function automatic int fold_width(input int w, input int m, input int n);
    int r;
    if (w <= m) r = m;
    else if (w - m + n > m) r = w - m + n;
    else r = m;
    return r;
  endfunction

  // Width after k successive folds.
  function automatic int width_after(input int w, input int m, input int n, input int k);
    int x;
    x = w;
    for (int i = 0; i < k; i++) x = fold_width(x, m, n);
    return x;
  endfunction

  // Number of folds needed until the width equals m.
  function automatic int pass_count(input int w, input int m, input int n);
    int x;
    int c;
    x = w;
    c = 0;
    while (x > m) begin
      x = fold_width(x, m, n);
      c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/gf_fold_pass.sv
module gf_fold_pass #(
  parameter int M     = gf233_pkg::DEF_FIELD_M,
  parameter int N     = gf233_pkg::DEF_MID_N,
  parameter int W_IN  = 2 * gf233_pkg::DEF_FIELD_M - 1,
  parameter int W_OUT = gf233_pkg::fold_width(W_IN, M, N)
) (
  input  logic [W_IN-1:0]  in_i,
  output logic [W_OUT-1:0] out_o
);

  logic [W_OUT-1:0] acc;

  always_comb begin
    acc = '0;
    acc[M-1:0] = in_i[M-1:0];
    for (int i = M; i < W_IN; i++) begin
      acc[i - M]     = acc[i - M]     ^ in_i[i];
      acc[i - M + N] = acc[i - M + N] ^ in_i[i];
    end
  end

  assign out_o = acc;

endmodule

// File: rtl/gf_rst_sync.sv
module gf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shf_q;
  logic [STAGES-1:0] shf_d;

  always_comb begin
    shf_d = {shf_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shf_q <= '0;
    else        shf_q <= shf_d;
  end

  assign rst_sync_n = shf_q[STAGES-1];

endmodule

// File: rtl/gf_out_stage.sv
module gf_out_stage #(
  parameter int W       = gf233_pkg::DEF_FIELD_M,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  if (OUT_REG) begin : g_reg
    logic [W-1:0] val_q;
    logic [W-1:0] val_d;

    always_comb begin
      val_d = val_q;
      if (en_i) val_d = d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign q_o = val_q;
  end else begin : g_wire
    assign q_o = d_i;
  end

endmodule

// File: rtl/gf233_reduce.sv
module gf233_reduce #(
  parameter int FIELD_M    = gf233_pkg::DEF_FIELD_M,
  parameter int MID_N      = gf233_pkg::DEF_MID_N,
  parameter bit OUT_REG    = 1'b1,
  parameter int RST_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_i,
  input  logic [2*FIELD_M-2:0]   prod_i,
  output logic [FIELD_M-1:0]     rem_o
);

  localparam int IN_W     = 2 * FIELD_M - 1;
  localparam int NUM_PASS = gf233_pkg::pass_count(IN_W, FIELD_M, MID_N);

  logic rst_ok_n;

  gf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ok_n)
  );

  for (genvar k = 0; k < NUM_PASS; k++) begin : g_pass
    localparam int WI = gf233_pkg::width_after(IN_W, FIELD_M, MID_N, k);
    localparam int WO = gf233_pkg::width_after(IN_W, FIELD_M, MID_N, k + 1);
    logic [WI-1:0] fin;
    logic [WO-1:0] fout;

    if (k == 0) begin : g_first
      assign fin = prod_i;
    end else begin : g_next
      assign fin = g_pass[k-1].fout;
    end

    gf_fold_pass #(
      .M     (FIELD_M),
      .N     (MID_N),
      .W_IN  (WI),
      .W_OUT (WO)
    ) u_fold (
      .in_i  (fin),
      .out_o (fout)
    );
  end

  logic [FIELD_M-1:0] reduced;
  assign reduced = g_pass[NUM_PASS-1].fout;

  gf_out_stage #(.W(FIELD_M), .OUT_REG(OUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_ok_n),
    .en_i  (en_i),
    .d_i   (reduced),
    .q_o   (rem_o)
  );

endmodule

// File: rtl/gf233_reduce_chk.sv
module gf233_reduce_chk #(
  parameter int M       = gf233_pkg::DEF_FIELD_M,
  parameter int N       = gf233_pkg::DEF_MID_N,
  parameter bit OUT_REG = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en_i,
  input logic [2*M-2:0] prod_i,
  input logic [M-1:0]   rem_o
);

  localparam int IN_W = 2 * M - 1;
  localparam logic [IN_W-1:0] IN_B233 = IN_W'(1) << M;
  localparam logic [IN_W-1:0] IN_TOP  = IN_W'(1) << (IN_W - 1);
  localparam logic [M-1:0] EXP_B233 = M'(1) | (M'(1) << N);
  localparam logic [M-1:0] EXP_TOP  = (M'(1) << (M - 2)) | (M'(1) << (2 * N - 2)) | (M'(1) << (N - 2));

  if (OUT_REG) begin : g_seq
    AST_ZERO_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && prod_i == '0) |=> rem_o == '0); // R1
    AST_LOW_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && prod_i[IN_W-1:M] == '0) |=> rem_o == $past(prod_i[M-1:0])); // R2
    AST_BIT233_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && prod_i == IN_B233) |=> rem_o == EXP_B233); // R3
    AST_TOP_BIT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && prod_i == IN_TOP) |=> rem_o == EXP_TOP); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(rem_o)); // R5
  end

endmodule

bind gf233_reduce gf233_reduce_chk #(
  .M       (FIELD_M),
  .N       (MID_N),
  .OUT_REG (OUT_REG)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_ok_n),
  .en_i   (en_i),
  .prod_i (prod_i),
  .rem_o  (rem_o)
);

// File: tb/tb_gf233_reduce.sv
module tb_gf233_reduce;

  localparam int M    = 233;
  localparam int IN_W = 465;
  localparam int NV   = 8;

  logic            clk;
  logic            rst_n;
  logic            en_i;
  logic [IN_W-1:0] prod_i;
  logic [M-1:0]    rem_o;

  int total = 0;
  int bad   = 0;

  gf233_reduce dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .prod_i (prod_i),
    .rem_o  (rem_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam logic [IN_W-1:0] VIN [NV] = '{
    IN_W'(0),                                   // R1 zero
    IN_W'(1) << 233,                            // R3
    IN_W'(1) << 464,                            // R4
    IN_W'(1) << 232,                            // R2
    {232'd0, {233{1'b1}}},                      // R2
    IN_W'(1) << 306,                            // R3
    IN_W'(1) << 307,                            // R3
    (IN_W'(1) << 233) | IN_W'(1)                // R1 cancel
  };
  localparam logic [M-1:0] VEXP [NV] = '{
    M'(0),
    M'(1) | (M'(1) << 74),
    (M'(1) << 231) | (M'(1) << 146) | (M'(1) << 72),
    M'(1) << 232,
    {233{1'b1}},
    (M'(1) << 147) | (M'(1) << 73),
    (M'(1) << 148) | (M'(1) << 74),
    M'(1) << 74
  };

  function automatic logic [M-1:0] ref_mod(input logic [IN_W-1:0] v);
    logic [IN_W-1:0] r;
    r = v;
    for (int i = IN_W - 1; i >= M; i--) begin
      if (r[i]) r = r ^ (IN_W'(1) << i) ^ (IN_W'(1) << (i - M + 74)) ^ (IN_W'(1) << (i - M));
    end
    return r[M-1:0];
  endfunction

  function automatic logic [IN_W-1:0] rand_wide();
    logic [IN_W-1:0] v;
    v = '0;
    for (int k = 0; k < 15; k++) v = {v[IN_W-33:0], 32'($urandom())};
    return v;
  endfunction

  task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [IN_W-1:0] v);
    @(negedge clk);
    prod_i = v;
    en_i   = 1'b1;
    @(negedge clk);
    en_i   = 1'b0;
  endtask

  initial begin
    #500us;
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [IN_W-1:0] a;
    logic [IN_W-1:0] b;
    logic [M-1:0]    ra;
    logic [M-1:0]    held;
    rst_n  = 1'b0;
    en_i   = 1'b0;
    prod_i = '0;
    repeat (3) @(negedge clk);
    check("R6 reset state", rem_o, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table: R1..R4 cases
    for (int i = 0; i < NV; i++) begin
      load(VIN[i]);
      check("R1 table", rem_o, VEXP[i]);
    end

    // R1: random inputs against long division
    for (int i = 0; i < 40; i++) begin
      a = rand_wide();
      load(a);
      check("R1 random", rem_o, ref_mod(a));
    end

    // R2: random low-degree inputs pass through
    for (int i = 0; i < 6; i++) begin
      a = rand_wide();
      a[IN_W-1:M] = '0;
      load(a);
      check("R2 passthrough", rem_o, a[M-1:0]);
    end

    // R3 / R4 sweep of single bits against long division
    for (int i = M; i < IN_W; i += 7) begin
      a = IN_W'(1) << i;
      load(a);
      check("R3 single bit", rem_o, ref_mod(a));
    end
    load(IN_W'(1) << 464);
    check("R4 top bit", rem_o, (M'(1) << 231) | (M'(1) << 146) | (M'(1) << 72));

    // R8: linearity
    for (int i = 0; i < 5; i++) begin
      a = rand_wide();
      b = rand_wide();
      load(a);
      ra = rem_o;
      load(b);
      ra = ra ^ rem_o;
      load(a ^ b);
      check("R8 linearity", rem_o, ra);
    end

    // R5: enable low holds the output
    a = rand_wide();
    load(a);
    held = rem_o;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      prod_i = rand_wide();
      @(negedge clk);
      check("R5 hold", rem_o, held);
    end

    // R6: asynchronous clear
    load(IN_W'(1) << 300);
    #1;
    rst_n = 1'b0;
    #1;
    check("R6 async clear", rem_o, '0);

    // R7: synchronized release, third edge loads
    @(negedge clk);
    a = rand_wide();
    prod_i = a;
    en_i   = 1'b1;
    rst_n  = 1'b1;
    @(negedge clk);
    check("R7 edge1 ignored", rem_o, '0);
    @(negedge clk);
    check("R7 edge2 ignored", rem_o, '0);
    @(negedge clk);
    check("R7 edge3 loads", rem_o, ref_mod(a));
    en_i = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule